// File: doc/BRIEF.md
# Adjacent-Word Two-Bit Memory Upset Injector

This block runs a fault-injection campaign over a window of main memory. Each memory address selects one 128-bit access unit, made of four 32-bit words. For every unit in the window it performs one read-modify-write. It asks the memory arbiter for the bus, reads the unit, inverts the lowest bit of word 0 and the lowest bit of word 1, writes the unit back and releases the bus. The result is a correlated two-bit upset in neighbouring cells of a single access unit, rather than one isolated bit flip.

Software programs a start and an end unit address and then pulses an arm command. Campaigns usually target the data segment, with bounds inside 0x40000000 to 0x7FFFFFFF. An injection only begins while the workload-active input is high. That input marks the computational phase of the program under test, after initialisation and before output generation. After each write-back the block emits a one-cycle end-of-injection pulse. It then parks until an evaluation harness acknowledges, and only then moves to the next ascending address. A 32-bit injection counter is always visible.

Top module: `mcu_pair_injector`

## Requirements
- R1: Each injection reads the unit at `mem_addr` and writes back to the same address the read data XOR 128'h1_0000_0001. Only bit 0 (word 0, bits 31:0) and bit 32 (word 1, bits 63:32) change, and no other unit is written.
- R2: An accepted arm latches both bounds. The block then injects every unit address from start to end inclusive, exactly once each, in ascending order, and `mem_addr` never leaves the latched window.
- R3: A new injection starts (`mem_req` rises) only when `workload_active` was high in the previous cycle. While it stays low the block waits with `busy` high and no bus request.
- R4: `mem_req` rises before the read and stays high until the write-back has been issued, then falls. `mem_cmd_valid` is high only while `mem_gnt` is high. `mem_we` is 1 for a write and 0 for a read, and read data is taken in the cycle `mem_rvalid` is high.
- R5: One cycle after the write command, `inj_end` is high for exactly one cycle. No new request is made until `eval_ack` is seen high.
- R6: When the acknowledge arrives for the end address, `sweep_done` goes high and `busy` goes low. The address never wraps past the end bound, even when the end bound is the highest representable address.
- R7: An arm with end below start sets `sweep_err`, issues no memory request and leaves `inj_count` unchanged. The next valid arm clears `sweep_err`.
- R8: `inj_count` (32 bits) is cleared by an accepted arm and increases by exactly one per completed injection, in the cycle of the `inj_end` pulse.
- R9: After reset `busy`, `sweep_done`, `sweep_err`, `mem_req`, `mem_cmd_valid`, `inj_end` are 0 and `inj_count` is 0. An arm while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_addr | input | AW | First unit address of the sweep |
| cfg_end_addr | input | AW | Last unit address of the sweep (inclusive) |
| arm | input | 1 | One-cycle command that starts a sweep |
| workload_active | input | 1 | High while injection is permitted |
| eval_ack | input | 1 | Evaluation-done acknowledge |
| mem_req | output | 1 | Bus request to the memory arbiter |
| mem_gnt | input | 1 | Bus grant from the arbiter |
| mem_cmd_valid | output | 1 | Memory command strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Unit address of the command |
| mem_wdata | output | 128 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |
| inj_end | output | 1 | End-of-injection pulse |
| busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | Last sweep completed |
| sweep_err | output | 1 | Last arm rejected (end below start) |
| inj_count | output | 32 | Injections since the last accepted arm |

## Verification
The situation hardest to reach from the ports is a held-off campaign: the block is armed and mid-sweep, but progress is stalled by the outside world. Three things can stall it: the workload phase being inactive, the arbiter withholding the grant while the request is up, or the evaluator sitting on its acknowledge. The bench drives each of these in turn, and the memory model and grant gate are controlled from tasks. During each stall the bench watches the bus and the counter for any unwanted activity, then releases the stall and confirms that the sweep completes with the right units flipped. The highest address is swept alone to show that the walker stops without wrapping.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int UNIT_W  = WORD_W * N_WORDS;
  localparam int FIRST_HIT_WORD = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_ACT, ST_REQ, ST_RD, ST_RWAIT, ST_WR, ST_END, ST_EVAL
  } inj_state_t;

  // Mask with bit 0 set in the chosen word and in its upper neighbour.
  function automatic logic [UNIT_W-1:0] pair_mask(input int first_word);
    logic [UNIT_W-1:0] m;
    m = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (w == first_word || w == first_word + 1) m[w*WORD_W] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [UNIT_W-1:0] corrupt_unit(input logic [UNIT_W-1:0] d);
    return d ^ pair_mask(FIRST_HIT_WORD);
  endfunction
endpackage

// File: rtl/inj_addr_walker.sv
module inj_addr_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          in_sweep,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  output logic [AW-1:0] cur_addr,
  output logic          at_last,
  output logic          bounds_bad
);
  logic [AW-1:0] start_q, end_q, cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
    end else if (load) begin
      start_q <= cfg_start;
      end_q   <= cfg_end;
      cur_q   <= cfg_start;
    end else if (step) begin
      cur_q <= cur_q + {{(AW-1){1'b0}}, 1'b1};
    end
  end

  assign cur_addr   = cur_q;
  assign at_last    = (cur_q == end_q);
  assign bounds_bad = (cfg_end < cfg_start);

  // R2: the walking address stays inside the latched window
  assert_addr_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_sweep |-> (cur_q >= start_q && cur_q <= end_q));

  // R6: the sequencer never steps past the end bound
  assert_no_step_past_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last);
endmodule

// File: rtl/inj_event_counter.sv
module inj_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (inc)   count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  // R8: the counter only moves by one or back to zero
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));
endmodule

// File: rtl/inj_rmw_seq.sv
module inj_rmw_seq
  import inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              bounds_bad,
  input  logic              workload_active,
  input  logic              at_last,
  input  logic              eval_ack,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [UNIT_W-1:0] mem_rdata,
  output logic              load,
  output logic              step,
  output logic              fire,
  output logic              mem_req,
  output logic              mem_cmd_valid,
  output logic              mem_we,
  output logic [UNIT_W-1:0] mem_wdata,
  output logic              inj_end,
  output logic              busy,
  output logic              sweep_done,
  output logic              sweep_err
);
  inj_state_t state, nxt;
  logic [UNIT_W-1:0] wbuf;
  logic err_q, done_q;

  assign load = (state == ST_IDLE) && arm && !bounds_bad;
  assign step = (state == ST_EVAL) && eval_ack && !at_last;
  assign fire = (state == ST_END);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (load) nxt = ST_WAIT_ACT;
      ST_WAIT_ACT: if (workload_active) nxt = ST_REQ;
      ST_REQ:      if (mem_gnt) nxt = ST_RD;
      ST_RD:       if (mem_gnt) nxt = ST_RWAIT;
      ST_RWAIT:    if (mem_rvalid) nxt = ST_WR;
      ST_WR:       if (mem_gnt) nxt = ST_END;
      ST_END:      nxt = ST_EVAL;
      ST_EVAL:     if (eval_ack) nxt = at_last ? ST_IDLE : ST_WAIT_ACT;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wbuf   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && arm) begin
        err_q  <= bounds_bad;
        done_q <= 1'b0;
      end
      if (state == ST_RWAIT && mem_rvalid) wbuf <= corrupt_unit(mem_rdata);
      if (state == ST_EVAL && eval_ack && at_last) done_q <= 1'b1;
    end
  end

  assign mem_req       = (state == ST_REQ) || (state == ST_RD) ||
                         (state == ST_RWAIT) || (state == ST_WR);
  assign mem_cmd_valid = ((state == ST_RD) || (state == ST_WR)) && mem_gnt;
  assign mem_we        = (state == ST_WR);
  assign mem_wdata     = wbuf;
  assign inj_end       = (state == ST_END);
  assign busy          = (state != ST_IDLE);
  assign sweep_done    = done_q;
  assign sweep_err     = err_q;

  // R4: commands only under an active, granted request
  assert_cmd_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_gnt && mem_req));

  // R5: the end-of-injection pulse lasts one cycle
  assert_end_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_end |=> !inj_end);

  // R5: parked until the evaluator acknowledges
  assert_hold_for_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVAL && !eval_ack) |=> (state == ST_EVAL && !mem_req));

  // R3: a request only starts after the workload phase was active
  assert_start_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(workload_active));

  // R4: the bus is dropped right after the write command
  assert_release_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_we) |=> !mem_req);
endmodule

// File: rtl/mcu_pair_injector.sv
module mcu_pair_injector #(
  parameter int AW    = 32,
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              cfg_start_addr,
  input  logic [AW-1:0]              cfg_end_addr,
  input  logic                       arm,
  input  logic                       workload_active,
  input  logic                       eval_ack,
  output logic                       mem_req,
  input  logic                       mem_gnt,
  output logic                       mem_cmd_valid,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_addr,
  output logic [inj_pkg::UNIT_W-1:0] mem_wdata,
  input  logic                       mem_rvalid,
  input  logic [inj_pkg::UNIT_W-1:0] mem_rdata,
  output logic                       inj_end,
  output logic                       busy,
  output logic                       sweep_done,
  output logic                       sweep_err,
  output logic [CNT_W-1:0]           inj_count
);
  logic load_w, step_w, fire_w, at_last_w, bounds_bad_w;

  inj_addr_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(load_w), .step(step_w), .in_sweep(busy),
    .cfg_start(cfg_start_addr), .cfg_end(cfg_end_addr),
    .cur_addr(mem_addr), .at_last(at_last_w), .bounds_bad(bounds_bad_w)
  );

  inj_rmw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .bounds_bad(bounds_bad_w),
    .workload_active(workload_active), .at_last(at_last_w), .eval_ack(eval_ack),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .load(load_w), .step(step_w), .fire(fire_w),
    .mem_req(mem_req), .mem_cmd_valid(mem_cmd_valid), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .inj_end(inj_end), .busy(busy),
    .sweep_done(sweep_done), .sweep_err(sweep_err)
  );

  inj_event_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(load_w), .inc(fire_w), .count(inj_count)
  );

  // R7: a rejected sweep never touches the bus
  assert_err_blocks_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_err |-> (!mem_req && !busy));

  // R6: completion means idle
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> !busy);
endmodule

// File: tb/test_mcu_pair_injector.sv
module test_mcu_pair_injector;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [127:0] FLIP = 128'h1_0000_0001;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_start = '0, cfg_end = '0;
  logic arm = 0, active = 0, eval_ack = 0, gnt_allow = 1;
  logic mem_req, mem_gnt, mem_cmd_valid, mem_we, mem_rvalid, inj_end;
  logic busy, sweep_done, sweep_err;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic [31:0] inj_count;

  int checks = 0, fails = 0, ack_delay = 2;
  logic [127:0] mem [16];
  int n_wr = 0, n_cmd = 0, bad_cmd = 0, n_req_rise = 0;
  logic [AW-1:0] wr_log [64];
  logic req_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_gnt = mem_req && gnt_allow;

  mcu_pair_injector #(.AW(AW)) i_mcu_pair_injector (
    .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start), .cfg_end_addr(cfg_end),
    .arm(arm), .workload_active(active), .eval_ack(eval_ack),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_cmd_valid(mem_cmd_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .inj_end(inj_end),
    .busy(busy), .sweep_done(sweep_done), .sweep_err(sweep_err), .inj_count(inj_count)
  );

  function automatic logic [127:0] pattern(input int i);
    return {32'hC0DE_0000 + 32'(i*4+3), 32'h5A5A_0000 + 32'(i*4+2),
            32'hFFFF_FF00 + 32'(i*4+1), 32'h1234_0000 + 32'(i*4)};
  endfunction

  // memory model and bus monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= pattern(i);
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_cmd_valid && !mem_we;
      if (mem_cmd_valid && !mem_we) mem_rdata <= mem[mem_addr[3:0]];
      if (mem_cmd_valid && mem_we) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        if (n_wr < 64) wr_log[n_wr] <= mem_addr;
        n_wr <= n_wr + 1;
      end
      if (mem_cmd_valid) n_cmd <= n_cmd + 1;
      if (mem_cmd_valid && !mem_gnt) bad_cmd <= bad_cmd + 1;
      if (mem_req && !req_d) n_req_rise <= n_req_rise + 1;
      req_d <= mem_req;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_arm(input logic [AW-1:0] s, input logic [AW-1:0] e);
    @(negedge clk);
    cfg_start = s; cfg_end = e; arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  task automatic serve(input int limit);
    int cyc = 0;
    while (busy && cyc < limit) begin
      @(negedge clk); cyc++;
      if (inj_end) begin
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          check(!mem_req && !inj_end, "R5 parked while waiting for ack", {mem_req, inj_end}, 0);
        end
        eval_ack = 1;
        @(negedge clk);
        eval_ack = 0;
      end
    end
  endtask

  task automatic t_reset();
    check(!busy && !sweep_done && !sweep_err, "R9 reset flags", {busy, sweep_done, sweep_err}, 0);
    check(!mem_req && !mem_cmd_valid && !inj_end, "R9 reset bus", {mem_req, mem_cmd_valid, inj_end}, 0);
    check(inj_count == 0, "R9 reset count", inj_count, 0);
  endtask

  task automatic t_single();
    int w0 = n_wr;
    active = 1;
    do_arm(32'h4000_0003, 32'h4000_0003);
    serve(500);
    check(mem[3] == (pattern(3) ^ FLIP), "R1 unit flipped in bits 0 and 32", mem[3], pattern(3) ^ FLIP);
    check(mem[2] == pattern(2) && mem[4] == pattern(4), "R1 neighbour units untouched", mem[4], pattern(4));
    check(n_wr - w0 == 1, "R1 one write", n_wr - w0, 1);
    check(inj_count == 1 && sweep_done && !busy, "R6 single sweep done", inj_count, 1);
  endtask

  task automatic t_sweep(input bit restore);
    int w0 = n_wr;
    do_arm(32'h4000_0005, 32'h4000_0008);
    check(busy, "R9 busy after arm", busy, 1);
    do_arm(32'h4000_000A, 32'h4000_000A); // ignored while busy
    serve(2000);
    check(inj_count == 4, "R8 count after four units", inj_count, 4);
    check(n_wr - w0 == 4, "R2 four writes", n_wr - w0, 4);
    for (int i = 0; i < 4; i++) begin
      check(wr_log[w0+i] == 32'h4000_0005 + 32'(i), "R2 ascending order", wr_log[w0+i], 32'h4000_0005 + 32'(i));
      check(mem[5+i] == (restore ? pattern(5+i) : pattern(5+i) ^ FLIP), "R1 swept unit value",
            mem[5+i], restore ? pattern(5+i) : pattern(5+i) ^ FLIP);
    end
    check(mem[4] == pattern(4) && mem[9] == pattern(9) && mem[10] == pattern(10),
          "R2 outside window untouched / R9 arm ignored while busy", mem[10], pattern(10));
  endtask

  task automatic t_inactive();
    int r0, c0;
    active = 0;
    r0 = n_req_rise; c0 = n_cmd;
    do_arm(32'h4000_000B, 32'h4000_000B);
    repeat (20) @(negedge clk);
    check(n_req_rise == r0 && !mem_req, "R3 no request while inactive", n_req_rise - r0, 0);
    check(busy && inj_count == 0, "R3 waiting armed, count cleared", inj_count, 0);
    active = 1;
    serve(500);
    check(inj_count == 1 && mem[11] == (pattern(11) ^ FLIP), "R3 proceeds once active", mem[11], pattern(11) ^ FLIP);
    check(n_cmd - c0 == 2, "R1 one read plus one write", n_cmd - c0, 2);
  endtask

  task automatic t_grant();
    int c0 = n_cmd;
    gnt_allow = 0;
    do_arm(32'h4000_000C, 32'h4000_000C);
    repeat (15) @(negedge clk);
    check(mem_req && n_cmd == c0, "R4 request held, no command without grant", n_cmd - c0, 0);
    gnt_allow = 1;
    serve(500);
    check(bad_cmd == 0 && !mem_req, "R4 no ungranted command, bus released", bad_cmd, 0);
    check(mem[12] == (pattern(12) ^ FLIP), "R4 injection after grant", mem[12], pattern(12) ^ FLIP);
  endtask

  task automatic t_slow_ack();
    ack_delay = 25;
    do_arm(32'h4000_000D, 32'h4000_000E);
    serve(2000);
    check(inj_count == 2 && sweep_done, "R5 both units after slow acks", inj_count, 2);
    ack_delay = 2;
  endtask

  task automatic t_top();
    int w0 = n_wr;
    do_arm(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    serve(500);
    check(n_wr - w0 == 1 && !busy && sweep_done, "R6 stops at top address", n_wr - w0, 1);
    check(mem[15] == (pattern(15) ^ FLIP), "R6 top unit flipped", mem[15], pattern(15) ^ FLIP);
    w0 = n_wr;
    do_arm(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    serve(500);
    check(n_wr - w0 == 1 && !busy && inj_count == 1, "R6 no wrap at max address", n_wr - w0, 1);
  endtask

  task automatic t_reject();
    int r0 = n_req_rise;
    logic [31:0] c_before = inj_count;
    do_arm(32'h4000_0008, 32'h4000_0006);
    repeat (20) @(negedge clk);
    check(sweep_err && !busy, "R7 error flag", {sweep_err, busy}, 2'b10);
    check(n_req_rise == r0 && inj_count == c_before, "R7 no access, count kept", inj_count, c_before);
    do_arm(32'h4000_0001, 32'h4000_0001);
    check(!sweep_err, "R7 cleared by valid arm", sweep_err, 0);
    serve(500);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_sweep(0);
    t_inactive();
    t_grant();
    t_slow_ack();
    t_top();
    t_reject();
    t_sweep(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule